// File: doc/BRIEF.md
# Debug Breakpoint Comparator Bank

This block is a bank of four hardware breakpoint comparators, A, B, C and D. They watch the address, data and access qualifiers of one of two bus masters and raise one match flag per comparator. A debug state machine outside the block consumes these flags. Each comparator stores an address. Comparators A and C also store a data value and a per-bit data mask. Comparators B and D can require a given access size. Any comparator can require a read or a write.

A comparator can be switched to tagged mode. In that mode it ignores the bus and fires only when an external opcode-tracking input reports that the instruction at its stored address is about to execute. Two pairs, A/B and C/D, can instead be combined into an inclusive address range test that fires inside or outside the range. Comparators C and D can be lent to a trace-range function, and while they are lent they produce no match. All matching is held off while the core is in background debug mode.

Configuration is loaded through a single-cycle register write port. Matches are registered, so each qualifying bus cycle gives a one-clock pulse on the next clock.

Top module: `dbg_cmp_bank`

## Requirements
- R1: After reset every control field, address, data, mask and global register is zero, so `match_o` stays 0 for any bus activity.
- R2: Register writes use `cfg_addr[4]=0`, with `cfg_addr[3:2]` the comparator (0=A, 1=B, 2=C, 3=D) and `cfg_addr[1:0]` the field (0 control, 1 address, 2 data, 3 mask). Control bit 0 is enable. An enabled untagged comparator matches when the selected master's address, with bit 0 forced to 0, equals the stored address. Output bit i belongs to comparator i.
- R3: Control bit 1 picks the master: 0 watches the `bm0_*` bus and 1 watches the `bm1_*` bus. Activity on the other master never matches.
- R4: Only A and C compare data. A bus data bit counts only where its mask bit is 0, and a mask bit of 1 excludes it. Data and mask writes to B and D have no effect on matching.
- R5: Control bit 2 enables the direction check. With it set, control bit 3 requires a read (1) or a write (0). With it clear, direction is ignored.
- R6: On B and D only, control bit 4 enables the size check, and control bit 5 then requires a word (1) or a byte (0) access. On A and C these bits have no effect.
- R7: Control bit 6 sets tagged mode. The comparator then fires only when `exec_vld` is high, `exec_mst` equals its master select and `exec_addr` equals its stored address exactly. Bus activity, direction and size are all ignored.
- R8: Global register (`cfg_addr[4]=1`): bit 0 enables the A/B range and bit 1 makes it an outside test. Bits 2 and 3 do the same for C/D. A range uses the lower comparator's address as the low bound and the upper comparator's address as the high bound. Both bounds are inclusive and the full address is compared. The range also uses the lower comparator's enable, master and direction settings. The result appears on output 1 (A/B) or output 3 (C/D), and the lower output is held at 0.
- R9: Global bit 4 lends C and bit 5 lends D to trace-range definition. A lent comparator's output is 0, and a C/D range with either lent produces no match.
- R10: While `bdm_active` is high, all match outputs are 0 on the next clock.
- R11: A qualifying cycle shows on `match_o` one clock later as a single-cycle pulse. It does not appear in its own cycle and is not kept afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register select |
| cfg_wdata | input | max(AW,DW) | Configuration write data |
| bm0_vld | input | 1 | Master 0 access valid |
| bm0_addr | input | AW | Master 0 address |
| bm0_data | input | DW | Master 0 data |
| bm0_rd | input | 1 | Master 0 read (1) / write (0) |
| bm0_word | input | 1 | Master 0 word (1) / byte (0) |
| bm1_vld | input | 1 | Master 1 access valid |
| bm1_addr | input | AW | Master 1 address |
| bm1_data | input | DW | Master 1 data |
| bm1_rd | input | 1 | Master 1 read (1) / write (0) |
| bm1_word | input | 1 | Master 1 word (1) / byte (0) |
| exec_vld | input | 1 | Opcode tracker: instruction about to execute |
| exec_mst | input | 1 | Master issuing that instruction |
| exec_addr | input | AW | Address of that instruction |
| bdm_active | input | 1 | Background debug mode or background debug access |
| match_o | output | 4 | Registered match pulses, bit i for comparator i |

## Verification
Single comparators are tried with an aligned hit, the odd neighbour of an even stored address, and the next word address. This separates the bit-0 masking from a full compare. The same address is then driven on each master, and then on the matching address with the data, direction and size qualifiers each flipped one at a time. This shows which comparator honours which qualifier. Tagged mode is given bus hits without an execute report, and execute reports with the wrong master or with opposite qualifiers. Range tests probe both bounds and the addresses just beyond them, in inside and outside modes. Trace lending and debug mode are applied on top of a known hit to show that they suppress it.

// File: rtl/dbg_cmp_pkg.sv
package dbg_cmp_pkg;
  localparam int NCMP = 4;

  typedef struct packed {
    logic tag;   // bit 6
    logic sz;    // bit 5: 1 word, 0 byte
    logic sze;   // bit 4
    logic rw;    // bit 3: 1 read, 0 write
    logic rwe;   // bit 2
    logic sel;   // bit 1: master select
    logic en;    // bit 0
  } cmp_ctrl_t;

  typedef struct packed {
    logic trc_d;
    logic trc_c;
    logic cd_out;
    logic cd_en;
    logic ab_out;
    logic ab_en;
  } glb_cfg_t;

  localparam int CTRLW = $bits(cmp_ctrl_t);
  localparam int GLBW  = $bits(glb_cfg_t);
endpackage

// File: rtl/dbg_cmp_regs.sv
module dbg_cmp_regs
  import dbg_cmp_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  localparam int CW = (AW > DW) ? AW : DW
) (
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic                  we,
  input  logic [4:0]            waddr,
  input  logic [CW-1:0]         wdata,
  output cmp_ctrl_t [NCMP-1:0]  ctrl_q,
  output logic [NCMP-1:0][AW-1:0] addr_q,
  output logic [NCMP-1:0][DW-1:0] data_q,
  output logic [NCMP-1:0][DW-1:0] mask_q,
  output glb_cfg_t              glb_q
);
  logic glb_we;
  assign glb_we = we & waddr[4];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     glb_q <= '0;
    else if (glb_we) glb_q <= glb_cfg_t'(wdata[GLBW-1:0]);
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    logic sel_i, ctrl_we, addr_we;
    assign sel_i   = we & ~waddr[4] & (waddr[3:2] == 2'(i));
    assign ctrl_we = sel_i & (waddr[1:0] == 2'd0);
    assign addr_we = sel_i & (waddr[1:0] == 2'd1);

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)      ctrl_q[i] <= '0;
      else if (ctrl_we) ctrl_q[i] <= cmp_ctrl_t'(wdata[CTRLW-1:0]);
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)      addr_q[i] <= '0;
      else if (addr_we) addr_q[i] <= wdata[AW-1:0];
    end

    if ((i % 2) == 0) begin : g_data
      logic data_we, mask_we;
      assign data_we = sel_i & (waddr[1:0] == 2'd2);
      assign mask_we = sel_i & (waddr[1:0] == 2'd3);
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni)      data_q[i] <= '0;
        else if (data_we) data_q[i] <= wdata[DW-1:0];
      end
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni)      mask_q[i] <= '0;
        else if (mask_we) mask_q[i] <= wdata[DW-1:0];
      end
    end else begin : g_nodata
      assign data_q[i] = '0;
      assign mask_q[i] = '0;
    end
  end
endmodule

// File: rtl/dbg_cmp_unit.sv
module dbg_cmp_unit
  import dbg_cmp_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter bit HAS_DATA = 1'b1,
  parameter bit HAS_SIZE = 1'b0
) (
  input  cmp_ctrl_t        ctrl,
  input  logic [AW-1:0]    ref_addr,
  input  logic [DW-1:0]    ref_data,
  input  logic [DW-1:0]    ref_mask,
  input  logic             vld,
  input  logic             rd,
  input  logic             word,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    data,
  input  logic             exec_vld,
  input  logic             exec_mst,
  input  logic [AW-1:0]    exec_addr,
  output logic             hit
);
  logic addr_ok, dir_ok, size_ok, data_ok, data_eq, size_eq, tag_ok, bus_ok;

  always_comb begin
    addr_ok = ({addr[AW-1:1], 1'b0} == ref_addr);
    dir_ok  = ~ctrl.rwe | (rd == ctrl.rw);
    size_eq = ~ctrl.sze | (word == ctrl.sz);
    data_eq = (((data ^ ref_data) & ~ref_mask) == '0);
    size_ok = HAS_SIZE ? size_eq : 1'b1;
    data_ok = HAS_DATA ? data_eq : 1'b1;
    tag_ok  = exec_vld & (exec_mst == ctrl.sel) & (exec_addr == ref_addr);
    bus_ok  = vld & addr_ok & dir_ok & size_ok & data_ok;
    hit     = ctrl.en & (ctrl.tag ? tag_ok : bus_ok);
  end
endmodule

// File: rtl/dbg_cmp_bank.sv
module dbg_cmp_bank
  import dbg_cmp_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  localparam int CW = (AW > DW) ? AW : DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [4:0]    cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          bm0_vld,
  input  logic [AW-1:0] bm0_addr,
  input  logic [DW-1:0] bm0_data,
  input  logic          bm0_rd,
  input  logic          bm0_word,
  input  logic          bm1_vld,
  input  logic [AW-1:0] bm1_addr,
  input  logic [DW-1:0] bm1_data,
  input  logic          bm1_rd,
  input  logic          bm1_word,
  input  logic          exec_vld,
  input  logic          exec_mst,
  input  logic [AW-1:0] exec_addr,
  input  logic          bdm_active,
  output logic [3:0]    match_o
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  cmp_ctrl_t [NCMP-1:0]     ctrl;
  logic [NCMP-1:0][AW-1:0]  raddr;
  logic [NCMP-1:0][DW-1:0]  rdata, rmask;
  glb_cfg_t                 glb;

  dbg_cmp_regs #(.AW(AW), .DW(DW)) regs_i (
    .clk(clk), .rst_ni(rst_ni), .we(cfg_we), .waddr(cfg_addr),
    .wdata(cfg_wdata), .ctrl_q(ctrl), .addr_q(raddr), .data_q(rdata),
    .mask_q(rmask), .glb_q(glb)
  );

  logic [NCMP-1:0]          m_vld, m_rd, m_word, hit, dir_ok;
  logic [NCMP-1:0][AW-1:0]  m_addr;
  logic [NCMP-1:0][DW-1:0]  m_data;

  for (genvar i = 0; i < NCMP; i++) begin : g_unit
    assign m_vld[i]  = ctrl[i].sel ? bm1_vld  : bm0_vld;
    assign m_rd[i]   = ctrl[i].sel ? bm1_rd   : bm0_rd;
    assign m_word[i] = ctrl[i].sel ? bm1_word : bm0_word;
    assign m_addr[i] = ctrl[i].sel ? bm1_addr : bm0_addr;
    assign m_data[i] = ctrl[i].sel ? bm1_data : bm0_data;
    assign dir_ok[i] = ~ctrl[i].rwe | (m_rd[i] == ctrl[i].rw);

    dbg_cmp_unit #(
      .AW(AW), .DW(DW),
      .HAS_DATA((i % 2) == 0), .HAS_SIZE((i % 2) == 1)
    ) unit_i (
      .ctrl(ctrl[i]), .ref_addr(raddr[i]), .ref_data(rdata[i]),
      .ref_mask(rmask[i]), .vld(m_vld[i]), .rd(m_rd[i]), .word(m_word[i]),
      .addr(m_addr[i]), .data(m_data[i]), .exec_vld(exec_vld),
      .exec_mst(exec_mst), .exec_addr(exec_addr), .hit(hit[i])
    );
  end

  // range pairs: lower comparator supplies qualifiers and low bound
  logic in_ab, in_cd, rng_ab, rng_cd, cd_lent;
  logic [3:0] match_d, match_q;

  always_comb begin
    in_ab   = (m_addr[0] >= raddr[0]) & (m_addr[0] <= raddr[1]);
    in_cd   = (m_addr[2] >= raddr[2]) & (m_addr[2] <= raddr[3]);
    rng_ab  = ctrl[0].en & m_vld[0] & dir_ok[0] & (glb.ab_out ? ~in_ab : in_ab);
    rng_cd  = ctrl[2].en & m_vld[2] & dir_ok[2] & (glb.cd_out ? ~in_cd : in_cd);
    cd_lent = glb.trc_c | glb.trc_d;

    match_d[0] = glb.ab_en ? 1'b0   : hit[0];
    match_d[1] = glb.ab_en ? rng_ab : hit[1];
    match_d[2] = (glb.trc_c | glb.cd_en) ? 1'b0 : hit[2];
    if (glb.trc_d | (glb.cd_en & cd_lent)) match_d[3] = 1'b0;
    else if (glb.cd_en)                    match_d[3] = rng_cd;
    else                                   match_d[3] = hit[3];

    if (bdm_active) match_d = '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) match_q <= '0;
    else         match_q <= match_d;
  end
  assign match_o = match_q;

  // checks
  assert_bdm_quiet_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    bdm_active |=> (match_o == 4'b0000));
  assert_lent_c_silent_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    glb.trc_c |=> !match_o[2]);
  assert_lent_d_silent_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    glb.trc_d |=> !match_o[3]);
  assert_range_low_idle_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    glb.ab_en |=> !match_o[0]);
  assert_tag_needs_exec_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl[2].tag && !exec_vld) |=> !match_o[2]);
  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ctrl[3].en && !glb.cd_en) |=> !match_o[3]);
endmodule

// File: tb/dbg_cmp_bank_tb_top.sv
module dbg_cmp_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        bm0_vld, bm0_rd, bm0_word, bm1_vld, bm1_rd, bm1_word;
  logic [15:0] bm0_addr, bm0_data, bm1_addr, bm1_data;
  logic        exec_vld, exec_mst, bdm_active;
  logic [15:0] exec_addr;
  logic [3:0]  match_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  dbg_cmp_bank #(.AW(16), .DW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bm0_vld(bm0_vld), .bm0_addr(bm0_addr),
    .bm0_data(bm0_data), .bm0_rd(bm0_rd), .bm0_word(bm0_word),
    .bm1_vld(bm1_vld), .bm1_addr(bm1_addr), .bm1_data(bm1_data),
    .bm1_rd(bm1_rd), .bm1_word(bm1_word), .exec_vld(exec_vld),
    .exec_mst(exec_mst), .exec_addr(exec_addr), .bdm_active(bdm_active),
    .match_o(match_o)
  );

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: match got %b expected %b", req, got, exp);
    end
  endtask

  task automatic idle_bus();
    bm0_vld = 0; bm1_vld = 0; exec_vld = 0;
    bm0_addr = '0; bm1_addr = '0; bm0_data = '0; bm1_data = '0;
    bm0_rd = 0; bm1_rd = 0; bm0_word = 0; bm1_word = 0;
    exec_mst = 0; exec_addr = '0;
  endtask

  task automatic wr(input int cmp, input int fld, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = {1'b0, 2'(cmp), 2'(fld)}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wr_glb(input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 5'h10; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // one bus cycle, optional execute report, result sampled one clock later
  task automatic acc(input int m, input logic [15:0] a, input logic [15:0] d,
                     input logic rd, input logic wd, input logic ev,
                     input logic emst, input logic [15:0] ea,
                     input logic [3:0] exp, input string req);
    @(negedge clk);
    if (m == 0) begin bm0_vld = 1; bm0_addr = a; bm0_data = d; bm0_rd = rd; bm0_word = wd; end
    else if (m == 1) begin bm1_vld = 1; bm1_addr = a; bm1_data = d; bm1_rd = rd; bm1_word = wd; end
    exec_vld = ev; exec_mst = emst; exec_addr = ea;
    @(negedge clk);
    check(req, match_o, exp);
    idle_bus();
  endtask

  task automatic go(input int m, input logic [15:0] a, input logic [15:0] d,
                    input logic rd, input logic wd, input logic [3:0] exp,
                    input string req);
    acc(m, a, d, rd, wd, 1'b0, 1'b0, 16'h0, exp, req);
  endtask

  task automatic t_reset();
    check("R1", match_o, 4'b0000);
    go(0, 16'h0000, 16'h0000, 1, 1, 4'b0000, "R1");
    go(1, 16'h0001, 16'h0000, 0, 0, 4'b0000, "R1");
  endtask

  task automatic t_addr();
    wr(0, 3, 16'hFFFF);
    wr(0, 1, 16'h1234);
    wr(0, 0, 16'h0001);
    go(0, 16'h1235, 16'h0, 1, 1, 4'b0001, "R2 odd neighbour");
    go(0, 16'h1234, 16'h0, 1, 1, 4'b0001, "R2 exact");
    go(0, 16'h1236, 16'h0, 1, 1, 4'b0000, "R2 next word");
    go(1, 16'h1234, 16'h0, 1, 1, 4'b0000, "R3 other master");
    wr(0, 0, 16'h0003);
    go(1, 16'h1234, 16'h0, 1, 1, 4'b0001, "R3 master 1");
    go(0, 16'h1234, 16'h0, 1, 1, 4'b0000, "R3 master 0 ignored");
    wr(0, 0, 16'h0001);
  endtask

  task automatic t_timing();
    @(negedge clk);
    bm0_vld = 1; bm0_addr = 16'h1234; bm0_rd = 1;
    #1;
    check("R11 same cycle", match_o, 4'b0000);
    @(negedge clk);
    idle_bus();
    check("R11 next cycle", match_o, 4'b0001);
    @(negedge clk);
    check("R11 one pulse", match_o, 4'b0000);
  endtask

  task automatic t_data();
    wr(0, 3, 16'h00FF);
    wr(0, 2, 16'hAB00);
    go(0, 16'h1234, 16'hAB77, 1, 1, 4'b0001, "R4 masked low byte");
    go(0, 16'h1234, 16'hAC77, 1, 1, 4'b0000, "R4 data mismatch");
    wr(1, 1, 16'h2000);
    wr(1, 2, 16'h5555);
    wr(1, 3, 16'h0000);
    wr(1, 0, 16'h0001);
    go(0, 16'h2000, 16'h0000, 1, 1, 4'b0010, "R4 B ignores data");
    wr(1, 0, 16'h0000);
    wr(0, 3, 16'hFFFF);
  endtask

  task automatic t_dir();
    wr(0, 0, 16'h0005);
    go(0, 16'h1234, 16'h0, 1, 1, 4'b0000, "R5 read vs write");
    go(0, 16'h1234, 16'h0, 0, 1, 4'b0001, "R5 write");
    wr(0, 0, 16'h000D);
    go(0, 16'h1234, 16'h0, 1, 1, 4'b0001, "R5 read");
    go(0, 16'h1234, 16'h0, 0, 1, 4'b0000, "R5 write vs read");
  endtask

  task automatic t_size();
    wr(0, 0, 16'h0031);
    go(0, 16'h1234, 16'h0, 1, 0, 4'b0001, "R6 A ignores size");
    wr(0, 0, 16'h0000);
    wr(1, 0, 16'h0031);
    go(0, 16'h2000, 16'h0, 1, 0, 4'b0000, "R6 byte vs word");
    go(0, 16'h2000, 16'h0, 1, 1, 4'b0010, "R6 word");
    wr(1, 0, 16'h0011);
    go(0, 16'h2000, 16'h0, 1, 0, 4'b0010, "R6 byte");
    go(0, 16'h2000, 16'h0, 1, 1, 4'b0000, "R6 word vs byte");
    wr(1, 0, 16'h0000);
  endtask

  task automatic t_tag();
    wr(2, 3, 16'hFFFF);
    wr(2, 1, 16'h3000);
    wr(2, 0, 16'h0041);
    go(0, 16'h3000, 16'h0, 1, 1, 4'b0000, "R7 fetch without execute");
    acc(0, 16'h3000, 16'h0, 1, 1, 1, 0, 16'h3000, 4'b0100, "R7 execute");
    acc(2, 16'h0000, 16'h0, 1, 1, 1, 1, 16'h3000, 4'b0100 & 4'b0000, "R7 wrong master");
    acc(2, 16'h0000, 16'h0, 1, 1, 1, 0, 16'h3001, 4'b0000, "R7 exact address");
    wr(2, 0, 16'h0075);
    acc(0, 16'h3000, 16'h0, 1, 1, 1, 0, 16'h3000, 4'b0100, "R7 qualifiers ignored");
    wr(2, 0, 16'h0000);
  endtask

  task automatic t_range();
    wr(0, 1, 16'h4000);
    wr(1, 1, 16'h40FF);
    wr(0, 0, 16'h0001);
    wr_glb(16'h0001);
    go(0, 16'h4000, 16'h0, 1, 1, 4'b0010, "R8 low bound");
    go(0, 16'h40FF, 16'h0, 1, 1, 4'b0010, "R8 high bound");
    go(0, 16'h4100, 16'h0, 1, 1, 4'b0000, "R8 above");
    go(0, 16'h3FFF, 16'h0, 1, 1, 4'b0000, "R8 below");
    wr_glb(16'h0003);
    go(0, 16'h4100, 16'h0, 1, 1, 4'b0010, "R8 outside above");
    go(0, 16'h3FFF, 16'h0, 1, 1, 4'b0010, "R8 outside below");
    go(0, 16'h4080, 16'h0, 1, 1, 4'b0000, "R8 outside middle");
    wr_glb(16'h0000);
    wr(0, 0, 16'h0000);
  endtask

  task automatic t_trace();
    wr(2, 1, 16'h5000);
    wr(3, 1, 16'h5000);
    wr(2, 0, 16'h0001);
    wr(3, 0, 16'h0001);
    go(0, 16'h5000, 16'h0, 1, 1, 4'b1100, "R9 both plain");
    wr_glb(16'h0010);
    go(0, 16'h5000, 16'h0, 1, 1, 4'b1000, "R9 C lent");
    wr_glb(16'h0030);
    go(0, 16'h5000, 16'h0, 1, 1, 4'b0000, "R9 both lent");
    wr_glb(16'h0004);
    go(0, 16'h5000, 16'h0, 1, 1, 4'b1000, "R8 C/D range on output 3");
    wr_glb(16'h0014);
    go(0, 16'h5000, 16'h0, 1, 1, 4'b0000, "R9 range with C lent");
    wr_glb(16'h0000);
  endtask

  task automatic t_bdm();
    @(negedge clk);
    bdm_active = 1;
    go(0, 16'h5000, 16'h0, 1, 1, 4'b0000, "R10 debug mode");
    @(negedge clk);
    bdm_active = 0;
    go(0, 16'h5000, 16'h0, 1, 1, 4'b1100, "R10 released");
  endtask

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0; bdm_active = 0;
    idle_bus();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_addr();
    t_timing();
    t_data();
    t_dir();
    t_size();
    t_tag();
    t_range();
    t_trace();
    t_bdm();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100us;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule